// File: doc/BRIEF.md
# Stereo Soft Mute Fader with Silence Detector

The block sits in a stereo audio sample stream and applies a stepped gain to both channels of signed samples. A mute request starts a fade from full level down to silence over 64 equal gain steps. Clearing the request fades back up through the same steps. A fade that has started always runs to its end: the mute request is not looked at again until the gain reaches silence or full level. The number of samples spent on each gain step is a parameter. The default of 14 samples per step gives a fade of about 20 ms at a 44.1 kHz sample rate.

Alongside the fader, a detector watches the incoming samples. It raises a flag once both channels have carried exact zeros for a long, unbroken run. The default hold of 15435 samples is about 350 ms at 44.1 kHz. A single non-zero sample on either channel drops the flag and starts the count again.

Samples enter on a valid/ready input stream and leave on a registered valid/ready output stream. A sample moves (a "beat") when `s_valid` and `s_ready` are both high at a rising clock edge. The input is ready whenever the output register is empty, or when it is being emptied in that cycle. While `m_valid` is high and `m_ready` is low, the output data stays frozen and no input is accepted. All fade timing and zero counting advance on beats only, so back-pressure stretches a fade in time without changing its shape.

Top module: `fade_mute_zero`

## Requirements
- R1: After reset, `busy`, `zero_flag` and `m_valid` are low and `s_ready` is high. The gain is full, so the first beat passes its samples through unchanged.
- R2: `s_ready` equals `!m_valid || m_ready`. A beat loads the output register at that edge. While `m_valid` is high and `m_ready` is low, `m_valid`, `m_left` and `m_right` hold.
- R3: For a beat with input x while the gain is k (0 to 64), the output is floor(x*k/64), computed per channel. When k is 64 the output is exactly x; when k is 0 it is exactly 0.
- R4: When idle at full gain, a beat with `mute_req` high sets `busy`. The gain then drops by one after every further STEP_SAMPLES beats. `busy` clears on the beat where the gain reaches 0.
- R5: When idle at zero gain, a beat with `mute_req` low sets `busy`. The gain then rises by one after every STEP_SAMPLES beats, and `busy` clears when the gain reaches 64.
- R6: While `busy` is high, `mute_req` has no effect on the direction or pace of the fade.
- R7: Cycles without a beat leave the gain, the step position and `busy` unchanged.
- R8: `zero_flag` goes high after ZERO_HOLD consecutive beats in which both input samples are zero.
- R9: A beat carrying a non-zero sample on either channel makes `zero_flag` low from the next cycle and restarts the zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample pair valid |
| s_ready | output | 1 | Block can take an input sample pair |
| s_left | input | DW | Left input sample, signed |
| s_right | input | DW | Right input sample, signed |
| mute_req | input | 1 | Mute request, sampled on beats |
| m_valid | output | 1 | Output sample pair valid |
| m_ready | input | 1 | Downstream can take the output pair |
| m_left | output | DW | Scaled left sample, signed |
| m_right | output | DW | Scaled right sample, signed |
| busy | output | 1 | A fade is in progress |
| zero_flag | output | 1 | Both channels silent for the hold length |

## Verification
Every result is registered, so the scaled pair, `busy` and `zero_flag` all reflect a beat one clock after the edge that accepted it. The scaled pair is computed with the gain in force before that beat; `busy` and the zero flag include that beat's own update. The bench drives inputs on the falling edge and reads all outputs 1 ns after the rising edge that takes the beat. Each read is compared against a bench-side model that is stepped once per beat. During back-pressure and idle stretches, the bench reads the outputs on every cycle, to show that nothing moves without a beat.

// File: rtl/fmz_pkg.sv
package fmz_pkg;
  typedef enum logic {FADE_DN = 1'b0, FADE_UP = 1'b1} fade_dir_e;

  // Width able to hold values 0..n inclusive
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/fmz_fade_ctrl.sv
module fmz_fade_ctrl
  import fmz_pkg::*;
#(
  parameter int STEPS        = 64,
  parameter int STEP_SAMPLES = 14,
  localparam int GW = cnt_width(STEPS),
  localparam int CW = (STEP_SAMPLES > 1) ? $clog2(STEP_SAMPLES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          mute_req,
  output logic [GW-1:0] gain,
  output logic          busy,
  output fade_dir_e     dir
);
  logic [GW-1:0] gain_q, gain_nx;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  fade_dir_e     dir_q;

  always_comb begin
    gain_nx = (dir_q == FADE_UP) ? gain_q + 1'b1 : gain_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_q <= GW'(STEPS);
      busy_q <= 1'b0;
      dir_q  <= FADE_UP;
      cnt_q  <= '0;
    end else if (beat) begin
      if (!busy_q) begin
        // direction is latched here and held for the whole fade
        if (mute_req && gain_q == GW'(STEPS)) begin
          busy_q <= 1'b1;
          dir_q  <= FADE_DN;
          cnt_q  <= '0;
        end else if (!mute_req && gain_q == '0) begin
          busy_q <= 1'b1;
          dir_q  <= FADE_UP;
          cnt_q  <= '0;
        end
      end else if (cnt_q == CW'(STEP_SAMPLES - 1)) begin
        cnt_q  <= '0;
        gain_q <= gain_nx;
        if (gain_nx == '0 || gain_nx == GW'(STEPS)) busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign gain = gain_q;
  assign busy = busy_q;
  assign dir  = dir_q;
endmodule

// File: rtl/fmz_scaler.sv
module fmz_scaler
  import fmz_pkg::*;
#(
  parameter int DW    = 16,
  parameter int STEPS = 64,
  localparam int GW = cnt_width(STEPS),
  localparam int SH = $clog2(STEPS),
  localparam int PW = DW + GW + 1
) (
  input  logic signed [DW-1:0] x,
  input  logic        [GW-1:0] gain,
  output logic signed [DW-1:0] y
);
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shifted;

  always_comb begin
    prod    = PW'(x) * PW'($signed({1'b0, gain}));
    shifted = prod >>> SH;   // floor division by STEPS
    y       = shifted[DW-1:0];
  end
endmodule

// File: rtl/fmz_zero_watch.sv
module fmz_zero_watch
  import fmz_pkg::*;
#(
  parameter int ZERO_HOLD = 15435,
  localparam int ZW = cnt_width(ZERO_HOLD)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic both_zero,
  output logic flag
);
  logic [ZW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (beat) begin
      if (!both_zero)                     run_q <= '0;
      else if (run_q != ZW'(ZERO_HOLD))   run_q <= run_q + 1'b1;
    end
  end

  assign flag = (run_q == ZW'(ZERO_HOLD));
endmodule

// File: rtl/fade_mute_zero.sv
module fade_mute_zero
  import fmz_pkg::*;
#(
  parameter int DW           = 16,
  parameter int STEPS        = 64,
  parameter int STEP_SAMPLES = 14,
  parameter int ZERO_HOLD    = 15435
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_left,
  input  logic [DW-1:0] s_right,
  input  logic          mute_req,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_left,
  output logic [DW-1:0] m_right,
  output logic          busy,
  output logic          zero_flag
);
  localparam int GW = cnt_width(STEPS);
  localparam int NCH = 2;

  logic          beat;
  logic [GW-1:0] gain_q;
  fade_dir_e     dir_q;
  logic signed [DW-1:0] ch_in  [NCH];
  logic signed [DW-1:0] ch_out [NCH];
  logic [DW-1:0] out_l_q, out_r_q;
  logic          out_v_q;

  assign s_ready = !out_v_q || m_ready;
  assign beat    = s_valid && s_ready;
  assign ch_in[0] = $signed(s_left);
  assign ch_in[1] = $signed(s_right);

  fmz_fade_ctrl #(.STEPS(STEPS), .STEP_SAMPLES(STEP_SAMPLES)) u_fade (
    .clk(clk), .rst_n(rst_n), .beat(beat), .mute_req(mute_req),
    .gain(gain_q), .busy(busy), .dir(dir_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    fmz_scaler #(.DW(DW), .STEPS(STEPS)) u_scale (
      .x(ch_in[c]), .gain(gain_q), .y(ch_out[c])
    );
  end

  fmz_zero_watch #(.ZERO_HOLD(ZERO_HOLD)) u_zero (
    .clk(clk), .rst_n(rst_n), .beat(beat),
    .both_zero(s_left == '0 && s_right == '0), .flag(zero_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v_q <= 1'b0;
      out_l_q <= '0;
      out_r_q <= '0;
    end else if (beat) begin
      out_v_q <= 1'b1;
      out_l_q <= ch_out[0];
      out_r_q <= ch_out[1];
    end else if (m_ready) begin
      out_v_q <= 1'b0;
    end
  end

  assign m_valid = out_v_q;
  assign m_left  = out_l_q;
  assign m_right = out_r_q;
endmodule

// File: rtl/fmz_chk.sv
module fmz_chk #(
  parameter int DW    = 16,
  parameter int STEPS = 64,
  parameter int GW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic [DW-1:0] s_left,
  input logic [DW-1:0] s_right,
  input logic          m_valid,
  input logic          m_ready,
  input logic [DW-1:0] m_left,
  input logic [DW-1:0] m_right,
  input logic          busy,
  input logic          zero_flag,
  input logic [GW-1:0] gain_q,
  input logic          dir_q
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_left) && $stable(m_right)); // R2
  AST_GAIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    gain_q <= GW'(STEPS)); // R3
  AST_GAIN_MOVES_IN_FADE: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && !busy |=> $stable(gain_q)); // R4
  AST_DIR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy || $stable(dir_q)); // R6
  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && s_ready) |=> $stable(gain_q) && $stable(busy)); // R7
  AST_ZERO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && (s_left != '0 || s_right != '0) |=> !zero_flag); // R9
endmodule

bind fade_mute_zero fmz_chk #(.DW(DW), .STEPS(STEPS), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .s_left(s_left), .s_right(s_right), .m_valid(m_valid), .m_ready(m_ready),
  .m_left(m_left), .m_right(m_right), .busy(busy), .zero_flag(zero_flag),
  .gain_q(gain_q), .dir_q(dir_q)
);

// File: tb/fade_mute_zero_tb.sv
module fade_mute_zero_tb;
  localparam int DW = 16, STEPS = 64, STEP_N = 3, HOLD = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic s_valid = 1'b0, s_ready, mute_req = 1'b0, m_valid, m_ready = 1'b1;
  logic [DW-1:0] s_left = '0, s_right = '0, m_left, m_right;
  logic busy, zero_flag;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  // bench model state
  int mk = STEPS, mc = 0, zc = 0;
  bit mb = 1'b0, mup = 1'b1;

  fade_mute_zero #(.DW(DW), .STEPS(STEPS), .STEP_SAMPLES(STEP_N), .ZERO_HOLD(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .mute_req(mute_req),
    .m_valid(m_valid), .m_ready(m_ready), .m_left(m_left), .m_right(m_right),
    .busy(busy), .zero_flag(zero_flag)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int scl(input logic [DW-1:0] x, input int k);
    int p;
    p = $signed(x) * k;
    return p >>> 6;
  endfunction

  task automatic model(input logic [DW-1:0] l, input logic [DW-1:0] r, input bit mute,
                       output int el, output int er);
    el = scl(l, mk);
    er = scl(r, mk);
    if (!mb) begin
      if (mute && mk == STEPS) begin mb = 1; mup = 0; mc = 0; end
      else if (!mute && mk == 0) begin mb = 1; mup = 1; mc = 0; end
    end else if (mc == STEP_N - 1) begin
      mc = 0;
      mk = mup ? mk + 1 : mk - 1;
      if (mk == 0 || mk == STEPS) mb = 0;
    end else begin
      mc++;
    end
    if (l == 0 && r == 0) begin if (zc < HOLD) zc++; end
    else zc = 0;
  endtask

  task automatic beat(input logic [DW-1:0] l, input logic [DW-1:0] r, input bit mute,
                      input string tag);
    int el, er;
    @(negedge clk);
    s_valid = 1'b1; s_left = l; s_right = r; mute_req = mute; m_ready = 1'b1;
    model(l, r, mute, el, er);
    @(posedge clk); #1;
    chk(tag, "m_left", $signed(m_left), el);
    chk(tag, "m_right", $signed(m_right), er);
    chk(tag, "busy", busy, mb);
    chk("R8", "zero_flag", zero_flag, (zc == HOLD));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int ea, ear, eb, ebr;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk); #1;
    chk("R1", "busy", busy, 0);
    chk("R1", "zero_flag", zero_flag, 0);
    chk("R1", "m_valid", m_valid, 0);
    chk("R1", "s_ready", s_ready, 1);
    @(negedge clk) rst_n = 1'b1;

    beat(16'h1234, 16'hEDCC, 0, "R1");
    beat(16'h7FFF, 16'h8000, 0, "R3");
    for (int i = 0; i < 30; i++) beat(DW'($urandom), DW'($urandom), 0, "R3");

    // fade down, toggling the request mid-fade
    beat(DW'($urandom), DW'($urandom), 1, "R4");
    for (int i = 0; i < 60; i++) beat(DW'($urandom), DW'($urandom), bit'($urandom % 2), "R6");
    @(negedge clk) s_valid = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      chk("R7", "busy in stall", busy, 1);
    end
    beat(16'h4000, 16'hC000, 1, "R7");
    for (int i = 0; i < 150; i++) beat(DW'($urandom), DW'($urandom), 1, "R4");
    chk("R4", "model gain at end", mk, 0);
    beat(16'h7FFF, 16'h8000, 1, "R3");

    // fade back up
    for (int i = 0; i < 200; i++) beat(DW'($urandom), DW'($urandom), 0, "R5");
    chk("R5", "busy after fade up", busy, 0);
    beat(16'h8001, 16'h0001, 0, "R5");

    // back-pressure
    @(negedge clk) s_valid = 1'b0; m_ready = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    s_valid = 1'b1; s_left = 16'h0AAA; s_right = 16'hF555; mute_req = 1'b0; m_ready = 1'b0;
    model(16'h0AAA, 16'hF555, 0, ea, ear);
    @(posedge clk); #1;
    chk("R2", "m_valid", m_valid, 1);
    chk("R2", "m_left", $signed(m_left), ea);
    chk("R2", "s_ready", s_ready, 0);
    @(negedge clk) s_left = 16'h0123; s_right = 16'h0321;
    @(posedge clk); #1;
    chk("R2", "m_left held", $signed(m_left), ea);
    chk("R2", "m_right held", $signed(m_right), ear);
    chk("R2", "m_valid held", m_valid, 1);
    @(negedge clk) m_ready = 1'b1;
    model(16'h0123, 16'h0321, 0, eb, ebr);
    @(posedge clk); #1;
    chk("R2", "m_left next", $signed(m_left), eb);
    chk("R2", "m_right next", $signed(m_right), ebr);

    // silence detection
    for (int i = 0; i < HOLD + 5; i++) beat('0, '0, 0, "R8");
    chk("R8", "flag after hold", zero_flag, 1);
    beat('0, 16'h0001, 0, "R9");
    chk("R9", "flag after nonzero", zero_flag, 0);
    for (int i = 0; i < HOLD - 1; i++) beat('0, '0, 0, "R9");
    chk("R9", "flag one short of hold", zero_flag, 0);
    beat('0, '0, 0, "R8");
    chk("R8", "flag at hold", zero_flag, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule